// File: doc/BRIEF.md
# Synchronous Serial Adapter with Forwarded Clock

This block links a 16-bit bus host to a two-wire serial channel in each direction. On the transmit side it drives a data line and a clock line that it generates itself. On the receive side it takes a data line and a clock line, and it can recover bit timing from either line or from both. The hardware adds no start or stop bits. Each character is simply the low 1 to 16 bits of a word, sent least significant bit first. Any framing bits are part of the word that software writes, and software also checks them.

The host reaches the block through a pipelined Wishbone slave with four word registers:

| Offset | Name | Read | Write |
|---|---|---|---|
| 0 | data | oldest received word | queue a word to send |
| 1 | status | flag bits | ignored |
| 2 | divisor | current value | new value |
| 3 | configuration | current value | new value |

A transmit FIFO and a receive FIFO separate the bus from the shifters. A divisor register sets the bit period: one bit lasts 2·(divisor+1) clocks. A 16-bit divisor covers everything from a few hundred bits per second up to tens of megabits per second.

Top module: `sync_serial_adapter`

## Requirements
- R1: The slave never stalls. Every cycle with `wb_cyc_i` and `wb_stb_i` high is one accepted transfer. Exactly one cycle later `wb_ack_o` goes high, and for a read `wb_dat_o` holds the addressed register.
- R2: A write to offset 0 queues the word for transmission. If the transmit FIFO is full (status bit 0), the word is discarded and is never sent.
- R3: Each character holds configuration bits [3:0] + 1 bits and is sent least significant bit first. When no character is being sent, both `txd_o` and `txc_o` stay high.
- R4: Every bit lasts 2·(divisor+1) clocks. `txc_o` is low for the first divisor+1 clocks and high for the last divisor+1 clocks. `txd_o` does not change within a bit.
- R5: The status word at offset 1 is laid out as follows. Bit 0 is transmit FIFO full. Bit 1 is transmit FIFO empty. Bit 2 is receive FIFO empty. Bit 3 is receive overrun. Bits 15:4 read as zero.
- R6: A read at offset 0 returns the oldest received word, zero-extended, and removes it from the receive FIFO. When the receive FIFO is empty, the read returns 0 and nothing is removed.
- R7: If a character completes while the receive FIFO is full, the character is dropped and status bit 3 is set. Bit 3 stays set until a status read clears it.
- R8: With configuration bits [5:4] = 01, each rising edge of the receive clock samples the receive data line. A character is complete once it has the configured number of bits. Data-line edges have no effect in this mode.
- R9: With configuration bits [5:4] = 00, a falling edge on the data line starts a character. A bit timer restarts on every data edge and samples at mid-bit. The receive clock line is ignored.
- R10: With configuration bits [5:4] = 10 or 11, a character starts on a falling edge of either line. The bit timer restarts on any data edge or on a falling clock edge, so no start bit is required.
- R11: After reset the following hold. Status reads 0x0006. The divisor reads 0x000F. The configuration reads 0x0007, which means 8 bits in data-line mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Synchronous reset, active low |
| wb_cyc_i | input | 1 | Bus cycle active |
| wb_stb_i | input | 1 | Transfer request |
| wb_we_i | input | 1 | Write when high |
| wb_adr_i | input | 2 | Register offset |
| wb_dat_i | input | 16 | Write data |
| wb_dat_o | output | 16 | Read data, valid with ack |
| wb_ack_o | output | 1 | Transfer acknowledge |
| wb_stall_o | output | 1 | Always low |
| txd_o | output | 1 | Transmit data |
| txc_o | output | 1 | Forwarded transmit bit clock |
| rxd_i | input | 1 | Receive data, asynchronous |
| rxc_i | input | 1 | Receive clock, asynchronous |

## Verification
The following are checked on every cycle:
- the bus handshake: no stall, and each ack follows exactly one request;
- both transmit lines stay high whenever the shifter is idle;
- the data line is held through the high half of each bit;
- the overrun flag stays set until a status read, and it can only rise while the receive FIFO is full.

The other behaviours need directed scenarios, run with the lines looped back or driven by hand:
- bit order and width;
- the exact lengths of the half-periods;
- which line edges start and resynchronise a character in each mode;
- words dropped at a full transmit FIFO;
- empty reads.

// File: rtl/ssa_pkg.sv
// Shared definitions for the synchronous serial adapter.
package ssa_pkg;
    localparam int unsigned BUS_W = 16;

    // Register offsets on the host bus
    localparam logic [1:0] ADR_DATA = 2'd0;
    localparam logic [1:0] ADR_STAT = 2'd1;
    localparam logic [1:0] ADR_DIV  = 2'd2;
    localparam logic [1:0] ADR_CFG  = 2'd3;

    // Receive timing source
    typedef enum logic [1:0] {
        SYNC_ON_DATA  = 2'd0,
        SYNC_ON_CLK   = 2'd1,
        SYNC_ON_BOTH  = 2'd2,
        SYNC_ON_BOTH2 = 2'd3
    } sync_mode_e;
endpackage

// File: rtl/ssa_fifo.sv
// Synchronous first-in first-out queue.
// Assumes DEPTH is a power of two and at least 2. A push while full and a pop
// while empty are ignored. The head word is visible on dout_o while not empty.
module ssa_fifo #(
    parameter int unsigned W     = 16,
    parameter int unsigned DEPTH = 4
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         push_i,
    input  logic [W-1:0] din_i,
    input  logic         pop_i,
    output logic [W-1:0] dout_o,
    output logic         full_o,
    output logic         empty_o
);
    localparam int unsigned AW = $clog2(DEPTH);

    logic [W-1:0] mem [DEPTH];
    logic [AW:0]  wp, rp;

    assign empty_o = (wp == rp);
    assign full_o  = (wp[AW] != rp[AW]) && (wp[AW-1:0] == rp[AW-1:0]);
    assign dout_o  = mem[rp[AW-1:0]];

    // Storage write; contents need no reset
    always_ff @(posedge clk_i) begin
        if (push_i && !full_o) mem[wp[AW-1:0]] <= din_i;
    end

    // Pointer advance
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            wp <= '0;
            rp <= '0;
        end else begin
            if (push_i && !full_o) wp <= wp + 1'b1;
            if (pop_i && !empty_o) rp <= rp + 1'b1;
        end
    end
endmodule

// File: rtl/ssa_tx.sv
// Transmit shifter with forwarded clock.
// It takes a word whenever it is idle and avail_i is high, then sends
// nbits_m1_i+1 bits, least significant first. Each bit lasts 2*(div_i+1)
// clocks: the clock line is low for the first half and high for the second.
// Assumes the divisor and width stay fixed while a character is in flight.
module ssa_tx #(
    parameter int unsigned DATA_W = 16,
    parameter int unsigned CNT_W  = 4,
    parameter int unsigned DIV_W  = 16
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [DIV_W-1:0]  div_i,
    input  logic [CNT_W-1:0]  nbits_m1_i,
    input  logic              avail_i,
    input  logic [DATA_W-1:0] word_i,
    output logic              take_o,
    output logic              busy_o,
    output logic              txd_o,
    output logic              txc_o
);
    logic [DIV_W:0]  cnt;
    logic [DATA_W-1:0] sh;
    logic [CNT_W-1:0]  left;
    logic              busy;
    logic [DIV_W:0]  last_cnt, half_cnt;

    assign last_cnt = {div_i, 1'b1};
    assign half_cnt = {1'b0, div_i};
    assign take_o   = !busy && avail_i;
    assign busy_o   = busy;
    assign txd_o    = busy ? sh[0] : 1'b1;
    assign txc_o    = busy ? (cnt > half_cnt) : 1'b1;

    // Load, time and shift one character
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            busy <= 1'b0;
            cnt  <= '0;
            sh   <= '0;
            left <= '0;
        end else if (take_o) begin
            busy <= 1'b1;
            cnt  <= '0;
            sh   <= word_i;
            left <= nbits_m1_i;
        end else if (busy) begin
            if (cnt == last_cnt) begin
                cnt <= '0;
                sh  <= sh >> 1;
                if (left == '0) busy <= 1'b0;
                else            left <= left - 1'b1;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/ssa_rx.sv
// Receive shifter with a selectable timing source.
// Both lines pass through two synchroniser flops.
// - Clock mode: every rising clock edge samples the data line.
// - Data and both modes: a bit timer of period 2*(div_i+1) is started and
//   restarted by line edges, and it samples at mid-bit.
// Once a character reaches nbits_m1_i+1 bits, valid_o pulses for one cycle
// with the word, least significant bit received first.
// Assumes the mode and width change only while the lines are idle.
module ssa_rx
    import ssa_pkg::*;
#(
    parameter int unsigned DATA_W = 16,
    parameter int unsigned CNT_W  = 4,
    parameter int unsigned DIV_W  = 16
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              rxd_i,
    input  logic              rxc_i,
    input  sync_mode_e        mode_i,
    input  logic [CNT_W-1:0]  nbits_m1_i,
    input  logic [DIV_W-1:0]  div_i,
    output logic [DATA_W-1:0] word_o,
    output logic              valid_o
);
    localparam logic [DIV_W:0] ONE = 1;

    logic [2:0] ds, cs;
    logic d, dp, c, cp;
    logic d_edge, d_fall, c_rise, c_fall;
    logic clk_mode, data_only, resync, start, take, done, armed;
    logic [DIV_W:0] cnt;
    logic [CNT_W-1:0] idx;
    logic [DATA_W-1:0] word, wnext;

    assign d  = ds[1];
    assign dp = ds[2];
    assign c  = cs[1];
    assign cp = cs[2];
    assign d_edge = d ^ dp;
    assign d_fall = dp & ~d;
    assign c_rise = ~cp & c;
    assign c_fall = cp & ~c;

    assign clk_mode  = (mode_i == SYNC_ON_CLK);
    assign data_only = (mode_i == SYNC_ON_DATA);
    assign resync = d_edge | (!data_only & c_fall);
    assign start  = d_fall | (!data_only & c_fall);
    assign take   = clk_mode ? c_rise
                             : (armed && !resync && cnt == {1'b0, div_i});
    assign done   = take && (idx == nbits_m1_i);

    // Synchronise both lines and keep one cycle of history
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            ds <= 3'b111;
            cs <= 3'b111;
        end else begin
            ds <= {ds[1:0], rxd_i};
            cs <= {cs[1:0], rxc_i};
        end
    end

    // Bit timer: arm on a start edge, restart on resync edges
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            armed <= 1'b0;
            cnt   <= '0;
        end else if (clk_mode) begin
            armed <= 1'b0;
            cnt   <= '0;
        end else if (!armed) begin
            if (start) begin
                armed <= 1'b1;
                cnt   <= ONE;
            end
        end else begin
            if (done) armed <= 1'b0;
            if (resync)                    cnt <= ONE;
            else if (cnt == {div_i, 1'b1}) cnt <= '0;
            else                           cnt <= cnt + 1'b1;
        end
    end

    // Place the sampled bit at its position in the character
    always_comb begin
        wnext      = (idx == '0) ? '0 : word;
        wnext[idx] = d;
    end

    // Assemble and hand over characters
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            idx     <= '0;
            word    <= '0;
            word_o  <= '0;
            valid_o <= 1'b0;
        end else begin
            valid_o <= 1'b0;
            if (take) begin
                word <= wnext;
                if (done) begin
                    idx     <= '0;
                    word_o  <= wnext;
                    valid_o <= 1'b1;
                end else begin
                    idx <= idx + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/sync_serial_adapter.sv
// Top level: register file on a pipelined Wishbone slave, the two FIFOs,
// and the transmit and receive shifters.
// Assumes DATA_W is a power of two from 8 to 16 and DIV_W is at most 16.
// The slave never stalls; ack follows each request by one cycle.
module sync_serial_adapter
    import ssa_pkg::*;
#(
    parameter int unsigned DATA_W   = 16,
    parameter int unsigned DIV_W    = 16,
    parameter int unsigned TX_DEPTH = 4,
    parameter int unsigned RX_DEPTH = 4,
    parameter int unsigned DIV_RST  = 15
) (
    input  logic        clk_i,
    input  logic        rst_ni,
    input  logic        wb_cyc_i,
    input  logic        wb_stb_i,
    input  logic        wb_we_i,
    input  logic [1:0]  wb_adr_i,
    input  logic [15:0] wb_dat_i,
    output logic [15:0] wb_dat_o,
    output logic        wb_ack_o,
    output logic        wb_stall_o,
    output logic        txd_o,
    output logic        txc_o,
    input  logic        rxd_i,
    input  logic        rxc_i
);
    localparam int unsigned CNT_W = $clog2(DATA_W);

    logic [DIV_W-1:0]  div_q;
    logic [CNT_W-1:0]  nbits_q;
    sync_mode_e        mode_q;
    logic              ovr_q;
    logic              acc, wr, rd, st_rd;
    logic              tx_push, tx_take, tx_full, tx_empty, tx_busy;
    logic [DATA_W-1:0] tx_head, rx_head, rx_word;
    logic              rx_pop, rx_valid, rx_full, rx_empty;
    logic [BUS_W-1:0]  rdata;

    assign acc     = wb_cyc_i && wb_stb_i;
    assign wr      = acc && wb_we_i;
    assign rd      = acc && !wb_we_i;
    assign tx_push = wr && (wb_adr_i == ADR_DATA);
    assign rx_pop  = rd && (wb_adr_i == ADR_DATA);
    assign st_rd   = rd && (wb_adr_i == ADR_STAT);
    assign wb_stall_o = 1'b0;

    ssa_fifo #(.W(DATA_W), .DEPTH(TX_DEPTH)) u_tx_fifo (
        .clk_i(clk_i), .rst_ni(rst_ni),
        .push_i(tx_push), .din_i(wb_dat_i[DATA_W-1:0]),
        .pop_i(tx_take), .dout_o(tx_head),
        .full_o(tx_full), .empty_o(tx_empty)
    );

    ssa_tx #(.DATA_W(DATA_W), .CNT_W(CNT_W), .DIV_W(DIV_W)) u_tx (
        .clk_i(clk_i), .rst_ni(rst_ni),
        .div_i(div_q), .nbits_m1_i(nbits_q),
        .avail_i(!tx_empty), .word_i(tx_head),
        .take_o(tx_take), .busy_o(tx_busy),
        .txd_o(txd_o), .txc_o(txc_o)
    );

    ssa_rx #(.DATA_W(DATA_W), .CNT_W(CNT_W), .DIV_W(DIV_W)) u_rx (
        .clk_i(clk_i), .rst_ni(rst_ni),
        .rxd_i(rxd_i), .rxc_i(rxc_i),
        .mode_i(mode_q), .nbits_m1_i(nbits_q), .div_i(div_q),
        .word_o(rx_word), .valid_o(rx_valid)
    );

    ssa_fifo #(.W(DATA_W), .DEPTH(RX_DEPTH)) u_rx_fifo (
        .clk_i(clk_i), .rst_ni(rst_ni),
        .push_i(rx_valid), .din_i(rx_word),
        .pop_i(rx_pop), .dout_o(rx_head),
        .full_o(rx_full), .empty_o(rx_empty)
    );

    // Read multiplexer over the four registers
    always_comb begin
        case (wb_adr_i)
            ADR_DATA: rdata = rx_empty ? '0 : BUS_W'(rx_head);
            ADR_STAT: rdata = BUS_W'({ovr_q, rx_empty, tx_empty, tx_full});
            ADR_DIV:  rdata = BUS_W'(div_q);
            default:  rdata = BUS_W'({mode_q, nbits_q});
        endcase
    end

    // Bus response: ack and read data one cycle after acceptance
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            wb_ack_o <= 1'b0;
            wb_dat_o <= '0;
        end else begin
            wb_ack_o <= acc;
            if (rd) wb_dat_o <= rdata;
        end
    end

    // Divisor and configuration registers
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            div_q   <= DIV_W'(DIV_RST);
            nbits_q <= CNT_W'(7);
            mode_q  <= SYNC_ON_DATA;
        end else if (wr) begin
            if (wb_adr_i == ADR_DIV) div_q <= wb_dat_i[DIV_W-1:0];
            if (wb_adr_i == ADR_CFG) begin
                nbits_q <= wb_dat_i[CNT_W-1:0];
                mode_q  <= sync_mode_e'(wb_dat_i[CNT_W+1:CNT_W]);
            end
        end
    end

    // Sticky overrun flag, cleared by a status read
    always_ff @(posedge clk_i) begin
        if (!rst_ni)                  ovr_q <= 1'b0;
        else if (rx_valid && rx_full) ovr_q <= 1'b1;
        else if (st_rd)               ovr_q <= 1'b0;
    end
endmodule

// File: rtl/ssa_checker.sv
// Cycle-by-cycle properties of the serial adapter, attached by bind.
// Assumes it observes the top-level ports plus the transmit busy flag,
// the overrun flag, the receive FIFO full flag and the status-read strobe.
module ssa_checker (
    input logic clk_i,
    input logic rst_ni,
    input logic cyc_i,
    input logic stb_i,
    input logic ack_i,
    input logic stall_i,
    input logic txd_i,
    input logic txc_i,
    input logic tx_busy_i,
    input logic ovr_i,
    input logic rx_full_i,
    input logic st_rd_i
);
    AST_ACK_AFTER_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cyc_i && stb_i) |=> ack_i); // R1
    AST_NO_STRAY_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ack_i |-> $past(cyc_i && stb_i)); // R1
    AST_NEVER_STALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !stall_i); // R1
    AST_IDLE_LINES_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !tx_busy_i |-> (txd_i && txc_i)); // R3
    AST_TXD_HELD_HIGH_HALF: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tx_busy_i && $past(tx_busy_i) && txc_i && $past(txc_i)) |-> $stable(txd_i)); // R4
    AST_OVR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ovr_i && !st_rd_i) |=> ovr_i); // R7
    AST_OVR_ONLY_WHEN_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(ovr_i) |-> $past(rx_full_i)); // R7
endmodule

bind sync_serial_adapter ssa_checker u_ssa_checker (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .cyc_i(wb_cyc_i), .stb_i(wb_stb_i), .ack_i(wb_ack_o), .stall_i(wb_stall_o),
    .txd_i(txd_o), .txc_i(txc_o), .tx_busy_i(tx_busy),
    .ovr_i(ovr_q), .rx_full_i(rx_full), .st_rd_i(st_rd)
);

// File: tb/sync_serial_adapter_bench.sv
// Scoreboard bench. Writes queue the expected received words, and a
// monitor task drains the receive side and compares each word.
module sync_serial_adapter_bench;
    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic        rst_n, cyc, stb, we;
    logic [1:0]  adr;
    logic [15:0] wdat;
    wire  [15:0] rdat;
    wire         ack, stall, txd, txc;
    logic        lb, m_rxd, m_rxc;
    wire         rxd = lb ? txd : m_rxd;
    wire         rxc = lb ? txc : m_rxc;

    int n_cmp = 0;
    int n_bad = 0;
    logic [15:0] exp_q[$];

    sync_serial_adapter u_sync_serial_adapter (
        .clk_i(clk), .rst_ni(rst_n),
        .wb_cyc_i(cyc), .wb_stb_i(stb), .wb_we_i(we), .wb_adr_i(adr),
        .wb_dat_i(wdat), .wb_dat_o(rdat), .wb_ack_o(ack), .wb_stall_o(stall),
        .txd_o(txd), .txc_o(txc), .rxd_i(rxd), .rxc_i(rxc)
    );

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // One bus transfer; the result is sampled on the falling edge after acceptance
    task automatic bus(input bit w, input logic [1:0] a, input logic [15:0] d,
                       output logic [15:0] r);
        @(negedge clk);
        cyc = 1'b1; stb = 1'b1; we = w; adr = a; wdat = d;
        @(negedge clk);
        cyc = 1'b0; stb = 1'b0; we = 1'b0;
        r = rdat;
        check("R1 ack", {15'd0, ack}, 16'd1);
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        logic [15:0] r;
        bus(1'b1, a, d, r);
    endtask

    task automatic rd(input logic [1:0] a, output logic [15:0] r);
        bus(1'b0, a, 16'd0, r);
    endtask

    // Driver: queue a word for sending and record the expected received value
    task automatic send(input logic [15:0] w, input int nbits);
        wr(2'd0, w);
        exp_q.push_back(w & 16'((32'd1 << nbits) - 1));
    endtask

    // Monitor: wait for each received word and compare it with the scoreboard
    task automatic drain(input string tag);
        logic [15:0] st, got;
        while (exp_q.size() > 0) begin
            int tries = 0;
            st = 16'h0004;
            while (st[2] && tries < 4000) begin
                rd(2'd1, st);
                tries++;
            end
            if (st[2]) begin
                check({tag, " rx timeout"}, 16'd0, exp_q[0]);
                exp_q.delete();
            end else begin
                rd(2'd0, got);
                check(tag, got, exp_q.pop_front());
            end
        end
    endtask

    // Watchdog: ends a hung run as a failure
    initial begin
        repeat (150000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog R1: actual expired expected finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [15:0] r;
        logic [7:0]  got;
        int lo, hi, guard;
        cyc = 0; stb = 0; we = 0; adr = 0; wdat = 0;
        lb = 1'b1; m_rxd = 1'b1; m_rxc = 1'b1;
        rst_n = 1'b0;
        repeat (5) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // Reset state (R11, R5, R3)
        @(negedge clk);
        check("R3 idle lines", {14'd0, txd, txc}, 16'h0003);
        rd(2'd1, r); check("R5 reset status", r, 16'h0006);
        rd(2'd2, r); check("R11 reset divisor", r, 16'h000F);
        rd(2'd3, r); check("R11 reset config", r, 16'h0007);

        // Bit timing and bit order: divisor 2, clock mode, 8 bits (R4, R3, R8)
        wr(2'd2, 16'd2);
        wr(2'd3, 16'h0017);
        send(16'h00A5, 8);
        guard = 0;
        while (txc !== 1'b0 && guard < 50) begin @(negedge clk); guard++; end
        for (int b = 0; b < 8; b++) begin
            lo = 0;
            while (txc === 1'b0 && lo < 50) begin lo++; @(negedge clk); end
            got[b] = txd;
            hi = 0;
            while (txc === 1'b1 && hi < 20) begin hi++; @(negedge clk); end
            if (b == 0) begin
                check("R4 low half", 16'(lo), 16'd3);
                check("R4 high half", 16'(hi), 16'd3);
            end
        end
        check("R3 lsb first", {8'd0, got}, 16'h00A5);
        drain("R8 clock mode 8 bits");

        // Clock mode with other widths (R3, R8)
        wr(2'd3, 16'h001F);
        send(16'h1234, 16);
        send(16'hF00F, 16);
        drain("R8 clock mode 16 bits");
        wr(2'd3, 16'h0014);
        send(16'h0073, 5);
        send(16'h000A, 5);
        drain("R3 width 5 masks upper bits");

        // Data-line mode with software start/stop bits, divisor 7, 10 bits (R9)
        wr(2'd2, 16'd7);
        wr(2'd3, 16'h0009);
        send(16'h02B4, 10);
        send(16'h03FE, 10);
        send(16'h0200, 10);
        send(16'h02AA, 10);
        drain("R9 data mode");

        // Both mode: a word with no start bit still lands (R10)
        wr(2'd3, 16'h0027);
        send(16'h0096, 8);
        send(16'h0001, 8);
        drain("R10 both mode loopback");

        // Both mode, hand-driven: one clock fall with data held high (R10)
        lb = 1'b0;
        wr(2'd3, 16'h0023);
        @(negedge clk) m_rxc = 1'b0;
        @(negedge clk) m_rxc = 1'b1;
        exp_q.push_back(16'h000F);
        drain("R10 clock fall arms");

        // Data-line mode ignores the clock line (R9)
        wr(2'd3, 16'h0003);
        for (int i = 0; i < 20; i++) begin
            repeat (4) @(negedge clk);
            m_rxc = ~m_rxc;
        end
        m_rxc = 1'b1;
        repeat (200) @(negedge clk);
        rd(2'd1, r); check("R9 clock line ignored", r, 16'h0006);

        // Clock mode ignores the data line (R8)
        wr(2'd3, 16'h0013);
        for (int i = 0; i < 20; i++) begin
            repeat (4) @(negedge clk);
            m_rxd = ~m_rxd;
        end
        m_rxd = 1'b1;
        repeat (50) @(negedge clk);
        rd(2'd1, r); check("R8 data line ignored", r, 16'h0006);
        lb = 1'b1;

        // Overrun: five words into a four-deep receive FIFO (R7, R6)
        wr(2'd2, 16'd1);
        wr(2'd3, 16'h0017);
        send(16'h0011, 8);
        send(16'h0022, 8);
        send(16'h0033, 8);
        send(16'h0044, 8);
        repeat (400) @(negedge clk);
        wr(2'd0, 16'h0055);
        repeat (100) @(negedge clk);
        rd(2'd1, r); check("R7 overrun set", r, 16'h000A);
        rd(2'd1, r); check("R7 overrun cleared by read", r, 16'h0002);
        drain("R7 first four kept");
        rd(2'd0, r); check("R6 empty read returns zero", r, 16'h0000);
        rd(2'd1, r); check("R6 empty read removes nothing", r, 16'h0006);

        // Transmit FIFO full: sixth quick write is dropped (R2)
        wr(2'd2, 16'd20);
        wr(2'd3, 16'h0013);
        send(16'h0001, 4);
        send(16'h0002, 4);
        send(16'h0003, 4);
        send(16'h0004, 4);
        send(16'h0005, 4);
        rd(2'd1, r); check("R2 tx full flag", r, 16'h0005);
        wr(2'd0, 16'h0006);
        drain("R2 queued words sent");
        repeat (400) @(negedge clk);
        rd(2'd1, r); check("R2 dropped word never sent", r, 16'h0006);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule